// File: doc/BRIEF.md
# Multi-Mode Watchdog Timer with Power-of-Two Postscaler

This block guards a device against a stalled program. It runs from a slow free-running oscillator clock. A fixed prescaler turns that clock into a base tick, and a postscaler, whose length is chosen as a power of two, counts those ticks. If the count runs out before firmware restarts it, the block issues a request. While the device is running, that request is a reset. While the device is asleep, it is a wake-up.

A 2-bit configuration input chooses how the timer is enabled. It can be off in hardware, always on, on only while the device is awake, or gated by a software enable input. Four separate events restart the count from zero: a clear-watchdog pulse, a sleep-entry pulse, any change of the 3-bit oscillator frequency-select field, and an asserted clock-failure flag. The prescale ratio and the largest postscaler exponent are parameters. The defaults are a divide by 128 and an exponent of 20, which give a timeout from one base tick up to 2^20 base ticks.

Top module: `wdt_top`

## Requirements
- R1: After reset, both request outputs are low and all counts are zero, so the first timeout comes after one full period.
- R2: While the timer is enabled and nothing clears it, a timeout happens after PRE_DIV * 2^code clock cycles of counting, where code is the value of `post_sel`. A timeout while `asleep` is low gives a one-cycle pulse on `rst_req` in the cycle after the terminal count.
- R3: A `post_sel` code above MAX_EXP behaves exactly like MAX_EXP.
- R4: With `en_cfg` = 2'b00 the timer is off in hardware: counts are held at zero and no request is ever raised.
- R5: With `en_cfg` = 2'b01 the timer counts only while `asleep` is low. While `asleep` is high, counts stay at zero and no request is raised.
- R6: With `en_cfg` = 2'b10 the timer counts only while `sw_en` is high. While `sw_en` is low, counts stay at zero.
- R7: With `en_cfg` = 2'b11 the timer also counts during sleep. A timeout while `asleep` is high pulses `wake_req` instead of `rst_req`, and the two outputs are never high together.
- R8: A cycle with `clr_cmd` high returns both counters to zero.
- R9: A cycle with `sleep_cmd` high returns both counters to zero.
- R10: A cycle in which `freq_sel` differs from its value in the previous cycle returns both counters to zero.
- R11: A cycle with `clk_fail` high returns both counters to zero.
- R12: Each request is a single-cycle pulse. After a timeout the count restarts from zero, so timeouts repeat once per period while the timer stays enabled and is not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow free-running oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_cfg | input | 2 | Enable mode: 00 off, 01 awake only, 10 software, 11 always |
| sw_en | input | 1 | Software enable, used in mode 10 |
| asleep | input | 1 | High while the device is in sleep |
| sleep_cmd | input | 1 | One-cycle pulse on sleep entry, clears counts |
| clr_cmd | input | 1 | One-cycle clear-watchdog pulse |
| freq_sel | input | 3 | Oscillator frequency-select field; any change clears counts |
| clk_fail | input | 1 | Clock-failure flag, clears counts while high |
| post_sel | input | 5 | Postscaler exponent code; above MAX_EXP saturates |
| rst_req | output | 1 | One-cycle device reset request |
| wake_req | output | 1 | One-cycle wake-up request |

## Verification
The bench measures the cycle distance from a clear to the first pulse. An off-by-one in the prescaler wrap or in the postscaler terminal compare therefore shows up as a pulse one cycle early or late. It also restarts a nearly expired count with each of the four clear sources in turn. A design that missed one source would fire two cycles after that restart instead of a full period later. Mode tests hold the timer in a disabled state for several periods and then enable it. A design that froze the count instead of zeroing it would fire early, and one that ignored the mode would fire while disabled. Sleep-time timeouts in always-on mode must land on the wake output only, and a postscaler code of 31 must give the same period as MAX_EXP rather than wrapping to a short one.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_AWAKE = 2'b01,
        MODE_SOFT  = 2'b10,
        MODE_ON    = 2'b11
    } wdt_mode_e;

    typedef struct packed {
        logic rst;
        logic wake;
    } wdt_req_t;

endpackage

// File: rtl/wdt_gate.sv
module wdt_gate
    import wdt_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       sw_en,
    input  logic       asleep,
    output logic       run
);
    always_comb begin
        unique case (wdt_mode_e'(mode))
            MODE_OFF:   run = 1'b0;
            MODE_AWAKE: run = ~asleep;
            MODE_SOFT:  run = sw_en;
            default:    run = 1'b1;
        endcase
    end
endmodule

// File: rtl/wdt_clr_src.sv
module wdt_clr_src #(
    parameter int FS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_cmd,
    input  logic            sleep_cmd,
    input  logic            clk_fail,
    input  logic [FS_W-1:0] freq_sel,
    output logic            clear
);
    typedef struct packed {
        logic [FS_W-1:0] fsel;
    } src_st_t;

    src_st_t st_d, st_q;
    logic    fs_moved;

    always_comb begin
        st_d      = st_q;
        st_d.fsel = freq_sel;
        fs_moved  = (freq_sel != st_q.fsel);
        clear     = clr_cmd | sleep_cmd | clk_fail | fs_moved;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/wdt_chain.sv
module wdt_chain #(
    parameter int PRE_DIV = 128,
    parameter int MAX_EXP = 20,
    parameter int SEL_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic [SEL_W-1:0] post_sel,
    output logic             expire
);
    localparam int PRE_W  = $clog2(PRE_DIV);
    localparam int POST_W = MAX_EXP;

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [POST_W-1:0] post;
    } chain_st_t;

    chain_st_t         st_d, st_q;
    logic [SEL_W-1:0]  eff_exp;
    logic [POST_W-1:0] post_mask;
    logic              pre_wrap;
    logic              post_last;

    assign eff_exp = (post_sel > SEL_W'(MAX_EXP)) ? SEL_W'(MAX_EXP) : post_sel;

    for (genvar i = 0; i < POST_W; i++) begin : g_mask
        assign post_mask[i] = (eff_exp > SEL_W'(i));
    end

    always_comb begin
        st_d      = st_q;
        pre_wrap  = (st_q.pre == PRE_W'(PRE_DIV - 1));
        post_last = (st_q.post == post_mask);
        expire    = 1'b0;
        if (!run || clear) begin
            st_d = '0;
        end else if (pre_wrap) begin
            st_d.pre = '0;
            if (post_last) begin
                st_d.post = '0;
                expire    = 1'b1;
            end else begin
                st_d.post = st_q.post + 1'b1;
            end
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/wdt_top.sv
module wdt_top
    import wdt_pkg::*;
#(
    parameter int PRE_DIV = 128,
    parameter int MAX_EXP = 20,
    parameter int SEL_W   = 5,
    parameter int FS_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       en_cfg,
    input  logic             sw_en,
    input  logic             asleep,
    input  logic             sleep_cmd,
    input  logic             clr_cmd,
    input  logic [FS_W-1:0]  freq_sel,
    input  logic             clk_fail,
    input  logic [SEL_W-1:0] post_sel,
    output logic             rst_req,
    output logic             wake_req
);
    logic     run;
    logic     clear;
    logic     expire;
    wdt_req_t req_d, req_q;

    wdt_gate u_gate (
        .mode   (en_cfg),
        .sw_en  (sw_en),
        .asleep (asleep),
        .run    (run)
    );

    wdt_clr_src #(.FS_W(FS_W)) u_clr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_cmd   (clr_cmd),
        .sleep_cmd (sleep_cmd),
        .clk_fail  (clk_fail),
        .freq_sel  (freq_sel),
        .clear     (clear)
    );

    wdt_chain #(
        .PRE_DIV (PRE_DIV),
        .MAX_EXP (MAX_EXP),
        .SEL_W   (SEL_W)
    ) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .clear    (clear),
        .post_sel (post_sel),
        .expire   (expire)
    );

    always_comb begin
        req_d      = '0;
        req_d.rst  = expire & ~asleep;
        req_d.wake = expire &  asleep;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end

    assign rst_req  = req_q.rst;
    assign wake_req = req_q.wake;
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
    parameter int FS_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      en_cfg,
    input logic            asleep,
    input logic            sleep_cmd,
    input logic            clr_cmd,
    input logic [FS_W-1:0] freq_sel,
    input logic            clk_fail,
    input logic            rst_req,
    input logic            wake_req
);
    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_req && wake_req)); // R7
    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req); // R12
    AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |=> !wake_req); // R12
    AST_RST_ONLY_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> !$past(asleep)); // R2
    AST_WAKE_ONLY_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> $past(asleep)); // R7
    AST_HW_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (en_cfg == 2'b00) |=> !(rst_req || wake_req)); // R4
    AST_AWAKE_MODE_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en_cfg == 2'b01 && asleep) |=> !(rst_req || wake_req)); // R5
    AST_CLR_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cmd |=> !(rst_req || wake_req)); // R8
    AST_SLEEP_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_cmd |=> !(rst_req || wake_req)); // R9
    AST_FSEL_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_sel != $past(freq_sel)) |=> !(rst_req || wake_req)); // R10
    AST_FAIL_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        clk_fail |=> !(rst_req || wake_req)); // R11
endmodule

bind wdt_top wdt_chk #(.FS_W(FS_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_cfg    (en_cfg),
    .asleep    (asleep),
    .sleep_cmd (sleep_cmd),
    .clr_cmd   (clr_cmd),
    .freq_sel  (freq_sel),
    .clk_fail  (clk_fail),
    .rst_req   (rst_req),
    .wake_req  (wake_req)
);

// File: tb/wdt_top_tb_top.sv
module wdt_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PRE  = 4;
    localparam int MAXE = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] en_cfg = 2'b11;
    logic       sw_en = 1'b0;
    logic       asleep = 1'b0;
    logic       sleep_cmd = 1'b0;
    logic       clr_cmd = 1'b0;
    logic [2:0] freq_sel = 3'd0;
    logic       clk_fail = 1'b0;
    logic [4:0] post_sel = 5'd2;
    logic       rst_req, wake_req;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cycles = 0;
    string cur_req = "R1";

    wdt_top #(.PRE_DIV(PRE), .MAX_EXP(MAXE)) dut_i (
        .clk(clk), .rst_n(rst_n), .en_cfg(en_cfg), .sw_en(sw_en),
        .asleep(asleep), .sleep_cmd(sleep_cmd), .clr_cmd(clr_cmd),
        .freq_sel(freq_sel), .clk_fail(clk_fail), .post_sel(post_sel),
        .rst_req(rst_req), .wake_req(wake_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference: one integer count of enabled cycles since last clear
    longint m_cnt = 0;
    logic [2:0] m_fq = 3'd0;
    bit m_rst = 0, m_wake = 0;
    bit m_en, m_clr;
    int m_e;

    function automatic int period(input int code);
        int e = (code > MAXE) ? MAXE : code;
        return PRE * (1 << e);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_fq = 3'd0; m_rst = 0; m_wake = 0;
        end else begin
            case (en_cfg)
                2'b00: m_en = 0;
                2'b01: m_en = !asleep;
                2'b10: m_en = sw_en;
                default: m_en = 1;
            endcase
            m_clr = clr_cmd || sleep_cmd || clk_fail || (freq_sel != m_fq);
            m_fq = freq_sel;
            m_rst = 0; m_wake = 0;
            if (!m_en || m_clr) m_cnt = 0;
            else if (m_cnt + 1 == longint'(period(int'(post_sel)))) begin
                m_cnt = 0;
                if (asleep) m_wake = 1; else m_rst = 1;
            end else m_cnt = m_cnt + 1;
        end
    end

    always @(negedge clk) begin
        n_cmp++;
        if (rst_req !== m_rst || wake_req !== m_wake) begin
            n_bad++;
            $display("FAIL %s model: rst/wake=%b%b expected %b%b at %0t",
                     cur_req, rst_req, wake_req, m_rst, m_wake, $time);
        end
    end

    task automatic finish_up;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_bad++;
            $display("FAIL watchdog: run hung, cycles=%0d expected < 100000", cycles);
            finish_up();
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // count negedges until the first pulse; expect it at expn on the chosen output
    task automatic measure(input int expn, input bit want_wake, input string tag);
        int hit = 0;
        bit got_wake = 0;
        for (int i = 1; i <= expn + 4; i++) begin
            @(negedge clk);
            if (rst_req || wake_req) begin
                hit = i;
                got_wake = wake_req;
                break;
            end
        end
        check(hit == expn && got_wake == want_wake, tag,
              hit * 10 + int'(got_wake), expn * 10 + int'(want_wake));
    endtask

    task automatic quiet(input int n, input string tag);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (rst_req || wake_req) seen++;
        end
        check(seen == 0, tag, seen, 0);
    endtask

    // 0 clear, 1 sleep entry, 2 clock failure: one cycle high, called at a negedge
    task automatic evt(input int which);
        case (which)
            0: clr_cmd = 1;
            1: sleep_cmd = 1;
            default: clk_fail = 1;
        endcase
        @(negedge clk);
        clr_cmd = 0; sleep_cmd = 0; clk_fail = 0;
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        cur_req = "R1";
        check(rst_req == 0 && wake_req == 0, "R1 outputs in reset", {rst_req, wake_req}, 0);
        rst_n = 1;
        measure(period(2), 0, "R1 first period after reset");

        cur_req = "R12";
        @(negedge clk);
        check(rst_req == 0, "R12 pulse width", rst_req, 0);
        measure(period(2) - 1, 0, "R12 repeat period");

        cur_req = "R2";
        for (int c = 0; c < 4; c++) begin
            post_sel = 5'(c);
            evt(0);
            measure(period(c), 0, "R2 period per code");
        end

        cur_req = "R3";
        post_sel = 5'd31; evt(0);
        measure(period(MAXE), 0, "R3 code 31 saturates");
        post_sel = 5'(MAXE + 1); evt(0);
        measure(period(MAXE), 0, "R3 code above max saturates");

        post_sel = 5'd2; n = period(2);
        cur_req = "R4";
        en_cfg = 2'b00; evt(0);
        quiet(3 * n, "R4 hardware off");

        cur_req = "R5";
        en_cfg = 2'b01; asleep = 1;
        quiet(3 * n, "R5 awake-only mode asleep");
        asleep = 0;
        measure(n, 0, "R5 awake-only mode after wake");

        cur_req = "R6";
        en_cfg = 2'b10; sw_en = 0; evt(0);
        quiet(3 * n, "R6 software bit low");
        sw_en = 1;
        measure(n, 0, "R6 software bit high");

        cur_req = "R7";
        en_cfg = 2'b11; asleep = 1; evt(0);
        measure(n, 1, "R7 sleep timeout wakes");
        asleep = 0;

        cur_req = "R8";
        evt(0); quiet(n - 2, "R8 lead-in");
        evt(0); measure(n, 0, "R8 clear restarts");

        cur_req = "R9";
        evt(0); quiet(n - 2, "R9 lead-in");
        evt(1); measure(n, 0, "R9 sleep entry restarts");

        cur_req = "R10";
        evt(0); quiet(n - 2, "R10 lead-in");
        freq_sel = 3'd5; @(negedge clk);
        measure(n, 0, "R10 frequency change restarts");

        cur_req = "R11";
        evt(0); quiet(n - 2, "R11 lead-in");
        evt(2); measure(n, 0, "R11 clock failure restarts");

        repeat (4) @(negedge clk);
        finish_up();
    end
endmodule